// File: doc/BRIEF.md
# Console Serial Port Register Front End

This block puts a byte-wide register window in front of an emulated console serial port. Driver code sees only enough of a legacy serial port to probe for one, send characters, and take transmit and receive interrupts. Real line framing, baud timing, FIFOs and modem lines are absent. On the host side a synchronous register bus carries a 3-bit offset, a read strobe, a write strobe and byte-wide data. On the console side a receive byte stream with a valid/ready handshake comes in, and a transmit byte stream with a one-cycle valid goes out.

Two small state machines sit under the register logic. The receive holding slot has the states SLOT_EMPTY and SLOT_FULL. It moves from empty to full on "capture", when the console offers a byte while the slot is empty, and from full to empty on "take", a read of the data offset. The transmit re-arm timer has the states TMR_IDLE and TMR_COUNT. A data write causes "start", from either state. The timer leaves TMR_COUNT on "expire", when the count runs out, or on "cancel", when an enable write clears the transmit-empty enable. The register logic also keeps the transmit-interrupt pending flag, the enable register, the status-select latch and a sticky acknowledge-error flag. It drives the interrupt output.

Top module: `console_uart_regs`

## Requirements
- R1: The receive slot asserts `rx_ready` only while empty and captures `rx_byte` on a cycle with `rx_valid` and `rx_ready`. A read of offset 0 returns the held byte and empties the slot. While the slot is full, offered bytes are not taken and the held byte does not change.
- R2: A write to offset 0 puts the byte on `tx_byte` with `tx_valid` high for the one cycle after the write. This happens only when bit 7 is 0 and the byte is not 0x0C. All other bytes are dropped.
- R3: A write to offset 0 clears the transmit-pending flag and starts or restarts a delay of TX_DELAY cycles (default 300). Exactly TX_DELAY clock edges after the write edge, the flag is set if enable bit 1 is set.
- R4: A write to offset 1 stores the enable byte. If bit 1 of the byte is set, transmit becomes pending at that edge. Otherwise the pending flag is cleared and a running delay is cancelled.
- R5: A read of offset 1 returns 0x0F when the stored enable byte is exactly 0x0F, and 0x00 otherwise.
- R6: A read of offset 2 returns 0x00 when transmit is pending or the receive slot is full, and 0x01 otherwise.
- R7: A write to offset 3 latches the byte as the status select. The value 0x28, written while transmit is pending, clears the pending flag. Other values have no further effect.
- R8: A 0x28 write to offset 3 while transmit is not pending sets the sticky `ack_err` output and changes nothing else. Only reset clears `ack_err`.
- R9: A read of offset 5 while the select holds 0x03 clears the select to 0x00. It returns 0x10 if transmit is pending, else 0x20 if the receive slot is full, else 0x00.
- R10: Otherwise a read of offset 5 returns 0x64, with bit 0 set when the receive slot is full.
- R11: Writes to offset 4 have no effect. Reads of offsets 3, 4, 6 and 7 return 0x00.
- R12: `irq` is high when transmit is pending with enable bit 1 set, or when the receive slot is full.
- R13: Read data appears on `reg_rdata` one cycle after the read strobe, and the read's side effects take place at that same edge. After reset all flags, registers and `reg_rdata` are zero, and the slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| rx_byte | input | 8 | Console receive byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive slot empty and accepting |
| tx_byte | output | 8 | Byte sent to console |
| tx_valid | output | 1 | One-cycle transmit strobe |
| irq | output | 1 | Interrupt request |
| ack_err | output | 1 | Sticky flag for an acknowledge with nothing pending |

## Verification
A pending flag in the wrong state shows on `irq` and on the offset-2 and vector reads at the very next cycle. A timer that is off by one cycle shows only at expiry, so the bench samples `irq` one cycle before and one cycle after the expected edge. A slot state that has gone bad shows at once on `rx_ready`, and a lost or overwritten byte shows on the next offset-0 read. A select latch that fails to clear shows on the second offset-5 read, which returns a vector where 0x64 is expected.

// File: rtl/conuart_pkg.sv
package conuart_pkg;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_ISTAT = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CMD   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_MODEM = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_LSTAT = 3'd5;

    localparam logic [BYTE_W-1:0] CMD_TX_ACK  = 8'h28;
    localparam logic [BYTE_W-1:0] CMD_VEC_SEL = 8'h03;
    localparam logic [BYTE_W-1:0] IEN_ALL     = 8'h0F;
    localparam logic [BYTE_W-1:0] LSTAT_BASE  = 8'h64;
    localparam logic [BYTE_W-1:0] VEC_TX      = 8'h10;
    localparam logic [BYTE_W-1:0] VEC_RX      = 8'h20;
    localparam logic [BYTE_W-1:0] FORM_FEED   = 8'h0C;
    localparam int                IEN_TXE_BIT = 1;

    typedef enum logic {SLOT_EMPTY, SLOT_FULL} slot_state_t;
    typedef enum logic {TMR_IDLE, TMR_COUNT} tmr_state_t;

    // Printable or control characters of 7-bit code, form feed excluded
    function automatic logic byte_sendable(input logic [BYTE_W-1:0] b);
        return (b[BYTE_W-1] == 1'b0) && (b != FORM_FEED);
    endfunction
endpackage

// File: rtl/conuart_rx_slot.sv
module conuart_rx_slot
    import conuart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              take,
    output logic              full,
    output logic [BYTE_W-1:0] held
);
    slot_state_t state_q, state_d;
    logic [BYTE_W-1:0] held_q;
    logic capture;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (capture) held_q <= in_byte;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: if (in_valid) begin
                capture = 1'b1;
                state_d = SLOT_FULL;
            end
            SLOT_FULL: if (take) state_d = SLOT_EMPTY;
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = (state_q == SLOT_EMPTY);
        full     = (state_q == SLOT_FULL);
        held     = held_q;
    end

    assert_hold_when_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_FULL && !take) |=> (state_q == SLOT_FULL && $stable(held_q)));
endmodule

// File: rtl/conuart_tx_timer.sv
module conuart_tx_timer #(
    parameter int DELAY = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic expire
);
    import conuart_pkg::*;
    localparam int CNT_W = $clog2(DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY);

    tmr_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic at_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign at_end = (cnt_q == CNT_W'(1));

    // transitions: start restarts from any state, cancel wins over expiry
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_IDLE: if (start) begin
                state_d = TMR_COUNT;
                cnt_d   = CNT_LOAD;
            end
            TMR_COUNT: begin
                if (start) begin
                    cnt_d = CNT_LOAD;
                end else if (cancel || at_end) begin
                    state_d = TMR_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: state_d = TMR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        expire = (state_q == TMR_COUNT) && at_end && !start && !cancel;
    end

    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_COUNT) |-> (cnt_q != '0 && cnt_q <= CNT_LOAD));
    assert_expire_returns_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (state_q == TMR_IDLE));
endmodule

// File: rtl/console_uart_regs.sv
module console_uart_regs
    import conuart_pkg::*;
#(
    parameter int TX_DELAY = 300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [7:0]  rx_byte,
    input  logic        rx_valid,
    output logic        rx_ready,
    output logic [7:0]  tx_byte,
    output logic        tx_valid,
    output logic        irq,
    output logic        ack_err
);
    logic [BYTE_W-1:0] ien_q, sel_q, rdata_q, txb_q;
    logic              tx_pend_q, txv_q, err_q;
    logic              rx_full;
    logic [BYTE_W-1:0] rx_held;
    logic              wr_data, wr_ien, wr_cmd, rd_data, rd_lstat;
    logic              ack_hit, ack_miss, tmr_cancel, tmr_expire, vec_mode;
    logic [BYTE_W-1:0] rd_mux;

    assign wr_data  = reg_wr && (reg_addr == OFS_DATA);
    assign wr_ien   = reg_wr && (reg_addr == OFS_IEN);
    assign wr_cmd   = reg_wr && (reg_addr == OFS_CMD);
    assign rd_data  = reg_rd && (reg_addr == OFS_DATA);
    assign rd_lstat = reg_rd && (reg_addr == OFS_LSTAT);
    assign ack_hit  = wr_cmd && (reg_wdata == CMD_TX_ACK) && tx_pend_q;
    assign ack_miss = wr_cmd && (reg_wdata == CMD_TX_ACK) && !tx_pend_q;
    assign tmr_cancel = wr_ien && !reg_wdata[IEN_TXE_BIT];
    assign vec_mode = (sel_q == CMD_VEC_SEL);

    conuart_rx_slot u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_byte  (rx_byte),
        .in_valid (rx_valid),
        .in_ready (rx_ready),
        .take     (rd_data),
        .full     (rx_full),
        .held     (rx_held)
    );

    conuart_tx_timer #(.DELAY(TX_DELAY)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_data),
        .cancel (tmr_cancel),
        .expire (tmr_expire)
    );

    // read value selection
    always_comb begin
        rd_mux = '0;
        unique case (reg_addr)
            OFS_DATA:  rd_mux = rx_held;
            OFS_IEN:   rd_mux = (ien_q == IEN_ALL) ? IEN_ALL : 8'h00;
            OFS_ISTAT: rd_mux = {7'b0, !(tx_pend_q || rx_full)};
            OFS_LSTAT: begin
                if (vec_mode)
                    rd_mux = tx_pend_q ? VEC_TX : (rx_full ? VEC_RX : 8'h00);
                else
                    rd_mux = LSTAT_BASE | {7'b0, rx_full};
            end
            default:   rd_mux = 8'h00;
        endcase
    end

    // register state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q     <= '0;
            sel_q     <= '0;
            rdata_q   <= '0;
            txb_q     <= '0;
            txv_q     <= 1'b0;
            tx_pend_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            txv_q <= wr_data && byte_sendable(reg_wdata);
            if (wr_data) txb_q <= reg_wdata;
            if (reg_rd) rdata_q <= rd_mux;
            if (wr_ien) ien_q <= reg_wdata;
            if (wr_cmd) sel_q <= reg_wdata;
            else if (rd_lstat && vec_mode) sel_q <= '0;
            if (ack_miss) err_q <= 1'b1;
            // pending flag: writes override a timer expiry
            if (wr_data || ack_hit) tx_pend_q <= 1'b0;
            else if (wr_ien) tx_pend_q <= reg_wdata[IEN_TXE_BIT];
            else if (tmr_expire && ien_q[IEN_TXE_BIT]) tx_pend_q <= 1'b1;
        end
    end

    assign reg_rdata = rdata_q;
    assign tx_byte   = txb_q;
    assign tx_valid  = txv_q;
    assign ack_err   = err_q;
    assign irq       = (tx_pend_q && ien_q[IEN_TXE_BIT]) || rx_full;

    assert_tx_filtered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_byte != FORM_FEED && !tx_byte[7]));
    assert_ien_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ien && !reg_wdata[IEN_TXE_BIT]) |=> !tx_pend_q);
    assert_ien_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_IEN) |=> (reg_rdata == 8'h00 || reg_rdata == IEN_ALL));
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |=> ack_err);
    assert_sel_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lstat && vec_mode && !reg_wr) |=> (sel_q == 8'h00));
    assert_rx_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> irq);
endmodule

// File: tb/console_uart_regs_bench.sv
module console_uart_regs_bench;
    localparam int DLY = 300;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic [7:0] rx_byte = '0;
    logic rx_valid = 1'b0, rx_ready;
    logic [7:0] tx_byte;
    logic tx_valid, irq, ack_err;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    console_uart_regs #(.TX_DELAY(DLY)) u_console_uart_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .irq(irq), .ack_err(ack_err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push_rx(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R13 rdata", reg_rdata, 8'h00);
        check("R13 irq", {7'b0, irq}, 8'h00);
        check("R13 rx_ready", {7'b0, rx_ready}, 8'h01);
        check("R13 ack_err", {7'b0, ack_err}, 8'h00);
        rd(3'd5, v); check("R10 idle lstat", v, 8'h64);
        rd(3'd2, v); check("R6 none pending", v, 8'h01);
        rd(3'd1, v); check("R5 reset ien", v, 8'h00);
    endtask

    task automatic t_rx();
        logic [7:0] v;
        push_rx(8'h41);
        check("R1 full not ready", {7'b0, rx_ready}, 8'h00);
        check("R12 rx irq", {7'b0, irq}, 8'h01);
        rd(3'd5, v); check("R10 lstat rx", v, 8'h65);
        rd(3'd2, v); check("R6 rx pending", v, 8'h00);
        push_rx(8'h42);
        rd(3'd0, v); check("R1 held byte kept", v, 8'h41);
        check("R1 ready after take", {7'b0, rx_ready}, 8'h01);
        check("R12 irq drop", {7'b0, irq}, 8'h00);
        push_rx(8'h42);
        rd(3'd0, v); check("R1 second byte", v, 8'h42);
    endtask

    task automatic t_tx_filter();
        logic [7:0] bytes [6] = '{8'h41, 8'h0C, 8'h0A, 8'h7F, 8'h80, 8'h00};
        logic       sends [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
        for (int i = 0; i < 6; i++) begin
            wr(3'd0, bytes[i]);
            check("R2 tx_valid", {7'b0, tx_valid}, {7'b0, sends[i]});
            if (sends[i]) check("R2 tx_byte", tx_byte, bytes[i]);
            @(negedge clk);
            check("R2 one cycle", {7'b0, tx_valid}, 8'h00);
        end
    endtask

    task automatic t_ien();
        logic [7:0] v;
        wr(3'd1, 8'h0F);
        check("R4 set pending", {7'b0, irq}, 8'h01);
        rd(3'd1, v); check("R5 exact 0F", v, 8'h0F);
        wr(3'd1, 8'h07);
        rd(3'd1, v); check("R5 other value", v, 8'h00);
        check("R12 still pending", {7'b0, irq}, 8'h01);
        wr(3'd1, 8'h00);
        check("R4 clear pending", {7'b0, irq}, 8'h00);
        rd(3'd2, v); check("R6 clear", v, 8'h01);
    endtask

    task automatic t_timer();
        logic [7:0] v;
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h55);
        check("R3 write clears", {7'b0, irq}, 8'h00);
        repeat (DLY - 1) @(negedge clk);
        check("R3 before expiry", {7'b0, irq}, 8'h00);
        @(negedge clk);
        check("R3 at expiry", {7'b0, irq}, 8'h01);
        wr(3'd0, 8'h55);
        repeat (100) @(negedge clk);
        wr(3'd0, 8'h56);
        repeat (DLY - 1) @(negedge clk);
        check("R3 restart before", {7'b0, irq}, 8'h00);
        @(negedge clk);
        check("R3 restart expiry", {7'b0, irq}, 8'h01);
        wr(3'd0, 8'h57);
        repeat (50) @(negedge clk);
        wr(3'd1, 8'h00);
        repeat (DLY) @(negedge clk);
        rd(3'd2, v); check("R4 cancelled timer", v, 8'h01);
        wr(3'd1, 8'h08);
        wr(3'd0, 8'h58);
        repeat (DLY + 2) @(negedge clk);
        rd(3'd2, v); check("R3 disabled expiry", v, 8'h01);
    endtask

    task automatic t_vector();
        logic [7:0] v;
        wr(3'd1, 8'h02);
        wr(3'd3, 8'h03);
        rd(3'd5, v); check("R9 tx vector", v, 8'h10);
        rd(3'd5, v); check("R9 select cleared", v, 8'h64);
        wr(3'd3, 8'h28);
        check("R7 ack clears", {7'b0, irq}, 8'h00);
        check("R7 no err", {7'b0, ack_err}, 8'h00);
        push_rx(8'h33);
        wr(3'd3, 8'h03);
        rd(3'd5, v); check("R9 rx vector", v, 8'h20);
        rd(3'd0, v); check("R1 drain", v, 8'h33);
        wr(3'd3, 8'h03);
        rd(3'd5, v); check("R9 empty vector", v, 8'h00);
        wr(3'd3, 8'h12);
        rd(3'd5, v); check("R7 other select", v, 8'h64);
    endtask

    task automatic t_ack_err();
        logic [7:0] v;
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h28);
        check("R8 err set", {7'b0, ack_err}, 8'h01);
        check("R8 irq unchanged", {7'b0, irq}, 8'h00);
        rd(3'd2, v); check("R8 nothing pending", v, 8'h01);
        wr(3'd1, 8'h02);
        wr(3'd3, 8'h28);
        check("R8 sticky", {7'b0, ack_err}, 8'h01);
    endtask

    task automatic t_misc();
        logic [7:0] v;
        wr(3'd1, 8'h00);
        wr(3'd4, 8'hFF);
        rd(3'd5, v); check("R11 modem ignored lstat", v, 8'h64);
        rd(3'd2, v); check("R11 modem ignored istat", v, 8'h01);
        check("R11 modem ignored irq", {7'b0, irq}, 8'h00);
        for (int a = 3; a < 8; a++) begin
            if (a != 5) begin
                rd(3'(a), v); check("R11 unlisted read", v, 8'h00);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx();
        t_tx_filter();
        t_ien();
        t_timer();
        t_vector();
        t_ack_err();
        t_misc();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule